// File: doc/BRIEF.md
# Reload-Driven Trigger Sequencer

This block turns edges on a group of external event lines into trigger pulses placed at programmed offsets in time. Each event line has a two-bit qualifier that decides which of its edges count. Any qualified edge on any line produces one master reload. The reload starts a new control cycle. It loads a counter with a start value and restarts it, and the counter then advances at a prescaled rate. Eight compare values are checked against the counter. When the counter reaches a compare value, the matching trigger pulses.

Software writes the compare values into a shadow bank. The shadow bank is copied into the active bank only on a reload, so one control cycle always runs against one consistent set of values. A separate stop value halts the counter when it is reached. A mode bit selects the firing pattern. In triggered mode every enabled compare may fire in each control cycle. In sequential mode each control cycle is bound to one trigger, and successive reloads rotate through the triggers.

Configuration uses a write-only port with a four-bit word address and 32-bit data. Every register change takes effect at the clock edge of the write.

Top module: `reload_trig_seq`

## Requirements
- R1: After reset, `trig_o`, `reload_o` and `count_o` are all zero, the counter is halted, every line's qualifier is 00 (ignored) and the rotation pointer is 0.
- R2: The qualifier for line i sits at bits [2i+1:2i] of the edge-select register (address 0). 00 ignores the line, 01 takes rising edges, 10 takes falling edges and 11 takes both. An edge is detected against the value of the line registered on the previous clock.
- R3: The clock edge that sees a qualified edge is the reload edge. `reload_o` is high for exactly one clock after the reload edge. Qualified edges on several lines in the same clock produce a single reload.
- R4: At the reload edge the counter takes the reload value (address 2, bits [15:0]) and starts running. This applies whether the counter was running or halted.
- R5: The prescale code in control bits [2:1] (address 1) gives a divide of code+1. While running, the counter steps by one every code+1 clocks, and its first step comes code+1 clocks after the reload edge.
- R6: When the running counter equals the stop value (address 3, bits [15:0]), it halts at that value until the next reload.
- R7: Trigger k is enabled by control bit 8+k. An enabled trigger pulses `trig_o[k]` for one clock, starting the clock after the counter equals its active compare value. It fires at most once per control cycle, even while the counter is held on that value. No trigger fires before the first reload.
- R8: Writes to addresses 8+k (bits [15:0]) go to a shadow copy of compare k. The shadow copy becomes active only at the next reload edge.
- R9: With control bit 0 at 0 (triggered mode), every enabled trigger can fire once in the same control cycle.
- R10: Control bit 0 at 1 selects sequential mode. Each reload binds the new control cycle to the trigger named by the rotation pointer, and only that trigger may fire in the cycle. A reload in sequential mode then advances the pointer, wrapping from 7 to 0.
- R11: Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | External event lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| trig_o | output | 8 | Trigger pulses, one per compare |
| reload_o | output | 1 | Master reload pulse, one clock after the reload edge |
| count_o | output | 16 | Current counter value |

## Verification
The assertions assume that the event lines and the write port are synchronous to `clk_i` and change only between clock edges. They also assume that a compare write and a reload in the same clock are resolved in favour of the old shadow value. The stimulus drives every input on the falling clock edge. Random phases mix register writes with event toggles, so writes often land mid-cycle and next to reloads, and the reference model follows the same ordering. The rotation check starts from the reset pointer, and no sequential-mode reload happens before it.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int NUM_IN   = 16;
  localparam int NUM_TRIG = 8;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int PSC_W    = 2;
  localparam int TIDX_W   = $clog2(NUM_TRIG);

  localparam logic [ADDR_W-1:0] A_ESEL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 4'd2;
  localparam logic [ADDR_W-1:0] A_STOP   = 4'd3;

  localparam int CTRL_SEQ = 0;
  localparam int CTRL_PSC = 1;
  localparam int CTRL_EN  = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/rts_edge_qual.sv
module rts_edge_qual #(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   evt_i,
  input  logic [2*N-1:0] sel_i,
  output logic           hit_o
);
  logic [N-1:0] evt_q;
  logic [N-1:0] qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall;
    assign rise    = evt_i[i] & ~evt_q[i];
    assign fall    = ~evt_i[i] & evt_q[i];
    assign qual[i] = (sel_i[2*i] & rise) | (sel_i[2*i+1] & fall);
  end

  assign hit_o = |qual;

  assert_hit_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (evt_i != evt_q));
  assert_off_lines_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> !hit_o);
endmodule

// File: rtl/rts_timebase.sv
module rts_timebase #(
  parameter int CW = 16,
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] stop_val_i,
  input  logic [PW-1:0] psc_code_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] psc_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      psc_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      psc_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == stop_val_i) begin
        run_q <= 1'b0;
      end else if (psc_q == psc_code_i) begin
        psc_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        psc_q <= psc_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_load_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_hold_when_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !run_q) |=> (cnt_q == $past(cnt_q)));
  assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_q) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/rts_trig_bank.sv
module rts_trig_bank #(
  parameter int NT = 8,
  parameter int CW = 16,
  localparam int IW = $clog2(NT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          seq_i,
  input  logic [NT-1:0] en_i,
  input  logic          cmp_we_i,
  input  logic [IW-1:0] cmp_idx_i,
  input  logic [CW-1:0] cmp_data_i,
  input  logic [CW-1:0] cnt_i,
  output logic [NT-1:0] trig_o
);
  logic [CW-1:0] shd_q [NT];
  logic [CW-1:0] act_q [NT];
  logic [NT-1:0] fired_q, trig_q, fire;
  logic [IW-1:0] ptr_q, cur_q;
  logic          live_q;

  // shadow bank: software side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT; k++) shd_q[k] <= '0;
    end else if (cmp_we_i) begin
      shd_q[cmp_idx_i] <= cmp_data_i;
    end
  end

  // active bank: swapped only on reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT; k++) act_q[k] <= '0;
    end else if (load_i) begin
      for (int k = 0; k < NT; k++) act_q[k] <= shd_q[k];
    end
  end

  for (genvar k = 0; k < NT; k++) begin : g_cmp
    assign fire[k] = live_q && en_i[k] && !fired_q[k] && (cnt_i == act_q[k])
                     && (!seq_i || (cur_q == IW'(k)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= '0;
      trig_q  <= '0;
      live_q  <= 1'b0;
      ptr_q   <= '0;
      cur_q   <= '0;
    end else if (load_i) begin
      fired_q <= '0;
      trig_q  <= '0;
      live_q  <= 1'b1;
      cur_q   <= ptr_q;
      if (seq_i) ptr_q <= ptr_q + 1'b1;
    end else begin
      fired_q <= fired_q | fire;
      trig_q  <= fire;
    end
  end

  assign trig_o = trig_q;

  assert_quiet_before_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (trig_q == '0));
  assert_seq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i && $past(seq_i)) |-> $onehot0(trig_q));
  assert_ptr_rotates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seq_i) |=> (ptr_q == $past(ptr_q) + IW'(1)));
  for (genvar k = 0; k < NT; k++) begin : g_once
    assert_fire_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fired_q[k] && !load_i) |=> !trig_q[k]);
  end
endmodule

// File: rtl/reload_trig_seq.sv
module reload_trig_seq
  import rts_pkg::*;
#(
  parameter int N_IN   = NUM_IN,
  parameter int N_TRIG = NUM_TRIG,
  parameter int CW     = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   evt_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [N_TRIG-1:0] trig_o,
  output logic              reload_o,
  output logic [CW-1:0]     count_o
);
  localparam int IW = $clog2(N_TRIG);

  logic [2*N_IN-1:0] esel_q;
  logic              seq_q;
  logic [PSC_W-1:0]  psc_q;
  logic [N_TRIG-1:0] en_q;
  logic [CW-1:0]     rld_q, stop_q;
  logic              hit, mrs_q, cmp_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esel_q <= '0;
      seq_q  <= 1'b0;
      psc_q  <= '0;
      en_q   <= '0;
      rld_q  <= '0;
      stop_q <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        A_ESEL:   esel_q <= cfg_wdata_i[2*N_IN-1:0];
        A_CTRL: begin
          seq_q <= cfg_wdata_i[CTRL_SEQ];
          psc_q <= cfg_wdata_i[CTRL_PSC +: PSC_W];
          en_q  <= cfg_wdata_i[CTRL_EN +: N_TRIG];
        end
        A_RELOAD: rld_q  <= cfg_wdata_i[CW-1:0];
        A_STOP:   stop_q <= cfg_wdata_i[CW-1:0];
        default: ;
      endcase
    end
  end

  // compare shadows occupy the upper half of the address space
  assign cmp_we = cfg_we_i && cfg_addr_i[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mrs_q <= 1'b0;
    else         mrs_q <= hit;
  end
  assign reload_o = mrs_q;

  rts_edge_qual #(.N(N_IN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .sel_i  (esel_q),
    .hit_o  (hit)
  );

  rts_timebase #(.CW(CW), .PW(PSC_W)) u_tbase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (hit),
    .load_val_i (rld_q),
    .stop_val_i (stop_q),
    .psc_code_i (psc_q),
    .cnt_o      (count_o)
  );

  rts_trig_bank #(.NT(N_TRIG), .CW(CW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (hit),
    .seq_i      (seq_q),
    .en_i       (en_q),
    .cmp_we_i   (cmp_we),
    .cmp_idx_i  (cfg_addr_i[IW-1:0]),
    .cmp_data_i (cfg_wdata_i[CW-1:0]),
    .cnt_i      (count_o),
    .trig_o     (trig_o)
  );

  assert_reload_starts_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> (count_o == $past(rld_q)));
  assert_reload_clears_trigs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> (trig_o == '0));
endmodule

// File: tb/reload_trig_seq_tb.sv
module reload_trig_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  trig_o;
  logic        reload_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  reload_trig_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .trig_o(trig_o), .reload_o(reload_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic [15:0] m_evq, m_cnt, m_rv, m_stop;
  logic [31:0] m_esel;
  logic        m_seq, m_run, m_live, m_mrs;
  logic [1:0]  m_pscc, m_psc;
  logic [7:0]  m_en, m_fired, m_trig;
  logic [2:0]  m_ptr, m_cur;
  logic [15:0] m_act [8];
  logic [15:0] m_shd [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_evq = '0; m_cnt = '0; m_rv = '0; m_stop = '0; m_esel = '0;
      m_seq = 0; m_run = 0; m_live = 0; m_mrs = 0; m_pscc = '0; m_psc = '0;
      m_en = '0; m_fired = '0; m_trig = '0; m_ptr = '0; m_cur = '0;
      for (int k = 0; k < 8; k++) begin m_act[k] = '0; m_shd[k] = '0; end
    end else begin
      logic hit;
      logic [7:0] fire;
      hit = 0;
      for (int i = 0; i < 16; i++) begin
        if (m_esel[2*i] && evt[i] && !m_evq[i]) hit = 1;
        if (m_esel[2*i+1] && !evt[i] && m_evq[i]) hit = 1;
      end
      for (int k = 0; k < 8; k++)
        fire[k] = m_live && m_en[k] && !m_fired[k] && (m_cnt == m_act[k]) &&
                  (!m_seq || m_cur == 3'(k));
      if (hit) begin
        m_cnt = m_rv; m_run = 1; m_psc = 0; m_live = 1; m_cur = m_ptr;
        if (m_seq) m_ptr = m_ptr + 1;
        for (int k = 0; k < 8; k++) m_act[k] = m_shd[k];
        m_fired = '0; m_trig = '0;
      end else begin
        if (m_run) begin
          if (m_cnt == m_stop) m_run = 0;
          else if (m_psc == m_pscc) begin m_psc = 0; m_cnt = m_cnt + 1; end
          else m_psc = m_psc + 1;
        end
        m_trig = fire; m_fired = m_fired | fire;
      end
      m_mrs = hit;
      m_evq = evt;
      if (we) begin
        if (addr[3]) m_shd[addr[2:0]] = wdata[15:0];
        else case (addr)
          4'd0: m_esel = wdata;
          4'd1: begin m_seq = wdata[0]; m_pscc = wdata[2:1]; m_en = wdata[15:8]; end
          4'd2: m_rv = wdata[15:0];
          4'd3: m_stop = wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // scoreboard and pulse tallies
  int tp [8];
  logic [15:0] tcnt [8];
  int rl = 0;
  initial for (int k = 0; k < 8; k++) begin tp[k] = 0; tcnt[k] = '0; end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 trig_o vs model", 32'(trig_o), 32'(m_trig));
      chk("R5 count_o vs model", 32'(count_o), 32'(m_cnt));
      chk("R3 reload_o vs model", 32'(reload_o), 32'(m_mrs));
      for (int k = 0; k < 8; k++) if (trig_o[k]) begin tp[k]++; tcnt[k] = count_o; end
      if (reload_o) rl++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 0;
  endtask

  task automatic edge_cnt(input int line, input logic v, input int exp, input string req);
    int base;
    base = rl;
    evt[line] = v;
    wt(4);
    chk(req, 32'(rl - base), 32'(exp));
  endtask

  // reload via line 0 set to rising-only
  task automatic reload0();
    evt[0] = 0; wt(2);
    evt[0] = 1; wt(1);
  endtask

  initial begin
    int snap [8];
    void'($urandom(32'd20240611));
    wt(3);
    rst_n = 1;
    wt(1);
    // R1 reset state
    chk("R1 trig_o after reset", 32'(trig_o), 0);
    chk("R1 count_o after reset", 32'(count_o), 0);
    chk("R1 reload_o after reset", 32'(reload_o), 0);
    edge_cnt(4, 1, 0, "R1 default qualifier ignores line");
    chk("R1 counter halted", 32'(count_o), 0);
    evt[4] = 0; wt(2);

    // R2 qualifier encodings on line 3
    wr(4'd0, 32'h1 << 6);
    edge_cnt(3, 1, 1, "R2 rising taken");
    edge_cnt(3, 0, 0, "R2 falling ignored in rise mode");
    wr(4'd0, 32'h2 << 6);
    edge_cnt(3, 1, 0, "R2 rising ignored in fall mode");
    edge_cnt(3, 0, 1, "R2 falling taken");
    wr(4'd0, 32'h3 << 6);
    edge_cnt(3, 1, 1, "R2 both mode rise");
    edge_cnt(3, 0, 1, "R2 both mode fall");
    edge_cnt(5, 1, 0, "R2 unselected line ignored");

    // R3 simultaneous edges merge into one pulse
    wr(4'd0, (32'h1 << 2) | (32'h1 << 4));
    begin
      int base;
      base = rl;
      evt[1] = 1; evt[2] = 1;
      wt(4);
      chk("R3 single reload for two lines", 32'(rl - base), 1);
    end

    // R4 R5 R6 counting with divide by 3
    wr(4'd0, 32'h1);
    wr(4'd2, 32'd100);
    wr(4'd3, 32'd105);
    wr(4'd1, 32'h4);
    evt[0] = 1; wt(1);
    chk("R4 reload value loaded", 32'(count_o), 100);
    wt(3); chk("R5 first step after 3 clocks", 32'(count_o), 101);
    wt(2); chk("R5 hold between ticks", 32'(count_o), 101);
    wt(1); chk("R5 second step", 32'(count_o), 102);
    wt(30); chk("R6 halted at stop value", 32'(count_o), 105);
    reload0();
    chk("R4 reload restarts halted counter", 32'(count_o), 100);

    // R7 R8 double buffering
    wr(4'd1, 32'h100);
    wr(4'd3, 32'd200);
    wr(4'd8, 32'd110);
    wr(4'd9, 32'd103);
    for (int k = 0; k < 8; k++) snap[k] = tp[k];
    reload0();
    wt(1);
    wr(4'd8, 32'd105);
    wt(20);
    chk("R8 old compare still active", 32'(tp[0] - snap[0]), 1);
    chk("R8 fired at old value", 32'(tcnt[0]), 111);
    chk("R7 disabled trigger silent", 32'(tp[1] - snap[1]), 0);
    reload0();
    wt(20);
    chk("R8 new compare after reload", 32'(tcnt[0]), 106);
    wr(4'd3, 32'd105);
    snap[0] = tp[0];
    reload0();
    wt(30);
    chk("R7 once while held on compare", 32'(tp[0] - snap[0]), 1);
    chk("R7 fired at held value", 32'(tcnt[0]), 105);

    // R9 triggered mode, all eight
    wr(4'd1, 32'hFF00);
    wr(4'd3, 32'd200);
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'(101 + k));
    for (int k = 0; k < 8; k++) snap[k] = tp[k];
    reload0();
    wt(30);
    for (int k = 0; k < 8; k++) chk("R9 every trigger once", 32'(tp[k] - snap[k]), 1);

    // R10 rotation from pointer 0 with wrap
    wr(4'd1, 32'hFF01);
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'd102);
    for (int j = 0; j < 9; j++) begin
      for (int k = 0; k < 8; k++) snap[k] = tp[k];
      reload0();
      wt(20);
      for (int k = 0; k < 8; k++)
        chk("R10 only pointed trigger fires", 32'(tp[k] - snap[k]), (k == j % 8) ? 1 : 0);
    end

    // R11 unused addresses
    wr(4'd1, 32'hFF00);
    for (int a = 4; a < 8; a++) wr(4'(a), 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) snap[k] = tp[k];
    reload0();
    chk("R11 reload value unchanged", 32'(count_o), 100);
    wt(30);
    for (int k = 0; k < 8; k++) chk("R11 triggers unchanged", 32'(tp[k] - snap[k]), 1);
    chk("R11 stop value unchanged", 32'(count_o), 130);

    // random phase, checked by the model
    for (int it = 0; it < 80; it++) begin
      logic [15:0] rv;
      rv = 16'($urandom % 16);
      wr(4'd0, $urandom);
      wr(4'd1, $urandom & 32'hFF07);
      wr(4'd2, 32'(rv));
      wr(4'd3, 32'(rv) + ($urandom % 60));
      for (int n = 0; n < 4; n++) begin
        if ($urandom % 2) wr(4'(8 + $urandom % 8), 32'(rv) + ($urandom % 45));
        evt = evt ^ 16'($urandom);
        wt(1 + $urandom % 40);
      end
    end

    wt(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule